// File: doc/BRIEF.md
# Hashed Destination Address Filter

This block decides whether a received frame is kept or dropped, using the frame's 48-bit destination address. It holds two 64-bin hash tables. One table is for individual (unicast) addresses and one is for group (multicast) addresses. Each bin is a single bit. An address is hashed by running all 48 of its bits, one bit per cycle, through a 32-bit CRC. Six bits of the CRC result then pick the bin.

A host command port loads an address by setting its bin in the matching table. A clear command empties both tables. The receive port takes a destination address and, once the hash is done, returns a one-cycle decision pulse with an accept flag.

A promiscuous input makes every frame acceptable. An external reject input, for example from an address CAM, can veto any frame while it is being hashed. A configuration input inverts the sense of that reject input, for a CAM that holds addresses to drop.

A single CRC engine serves both ports. While it is working, the block reports busy and ignores new requests.

Top module: `hashed_mac_filter`

## Requirements
- R1: After reset, and after a reset applied in the middle of an operation, `busy`, `dec_valid` and `dec_accept` are low and both tables are empty. A following non-promiscuous receive is therefore rejected.
- R2: The hash works as follows.
  - The CRC register is preset to all ones and uses polynomial 0x04C11DB7, shifting toward bit 31.
  - Address bit i (`addr[7:0]` is the first octet) is fed at step i, for i = 0..47. No final complement is applied.
  - The bin number is CRC bits [31:26]. Bits [31:30] pick one of four 16-bit table words and bits [29:26] pick the bit within that word.
- R3: A set command loads the bin of `cmd_addr` into a table. Bit 0 of the address picks the table: 1 selects the group table and 0 selects the individual table. A later receive of the same address is accepted.
- R4: Without promiscuous mode, a receive is accepted only if its bin is set in the table that its own bit 0 selects. The same bin set in the other table does not count.
- R5: A clear command (`cmd_valid` with `cmd_clear`=1) empties both tables in one cycle and never raises `busy`.
- R6: Timing of a request:
  - A request accepted at a clock edge raises `busy` from that edge for exactly 49 cycles.
  - A receive then gives `dec_valid` high for exactly one cycle, starting at the edge where `busy` falls.
  - `dec_accept` is low whenever `dec_valid` is low.
  - A set command gives no `dec_valid` pulse.
- R7: With `promisc` high in the last busy cycle and no reject, the frame is accepted whatever the tables hold.
- R8: Reject handling:
  - The effective reject level is `reject_in` XOR `reject_invert`.
  - If that level is high in any busy cycle of a receive, the frame is rejected, regardless of promiscuous mode or a hash hit.
  - A hash hit never causes a reject.
- R9: Requests arriving while `busy` is high are ignored. In an idle cycle where `rx_valid` and `cmd_valid` are both high, the receive is taken and the command is dropped.
- R10: Any address that hashes to a set bin of its table is accepted, even if it was never loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Host command request, taken only when idle |
| cmd_clear | input | 1 | 1: clear both tables, 0: load the bin of `cmd_addr` |
| cmd_addr | input | 48 | Address for the load command, first octet in bits [7:0] |
| rx_valid | input | 1 | Receive request, taken only when idle |
| rx_addr | input | 48 | Destination address of the received frame, first octet in bits [7:0] |
| promisc | input | 1 | Accept all frames unless rejected |
| reject_in | input | 1 | External reject level, sampled while busy |
| reject_invert | input | 1 | Inverts the sense of `reject_in` |
| busy | output | 1 | Hash engine working; new requests ignored |
| dec_valid | output | 1 | One-cycle pulse carrying the receive decision |
| dec_accept | output | 1 | Frame accepted; meaningful only with `dec_valid` |

## Verification
Some properties are checked by the assertions on every cycle:
- the 49-cycle busy window;
- the single-cycle decision pulse that only follows a busy window;
- `dec_accept` staying low outside that pulse;
- busy rising only after a request;
- the rule that an effective reject seen during the window forces a drop, while promiscuous mode without one forces a keep.

Other behaviour depends on table contents, and only the bench scenarios can show it. That covers:
- the exact CRC bin mapping;
- the table picked by the group bit;
- aliasing between addresses that share a bin;
- the effect of clearing;
- the dropping of requests made while busy or in the same cycle as a receive.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned MAC_W    = 48;
  localparam int unsigned CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HASH   = 2'd1,
    ST_FINISH = 2'd2
  } fsm_t;

  typedef enum logic {
    OP_RECV = 1'b0,
    OP_LOAD = 1'b1
  } op_t;
endpackage

// File: rtl/mhf_crc_serial.sv
module mhf_crc_serial #(
  parameter int unsigned DATA_W = 48,
  parameter int unsigned CRC_W  = 32,
  parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out,
  output logic              last_step
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CRC_W-1:0]  crc_q, crc_d, crc_step;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              run_q, run_d;
  logic              feedback;
  logic              en;

  assign feedback = crc_q[CRC_W-1] ^ sh_q[0];
  assign crc_step = {crc_q[CRC_W-2:0], 1'b0} ^ (feedback ? POLY : '0);
  assign en       = load | run_q;

  always_comb begin
    sh_d  = sh_q;
    crc_d = crc_q;
    cnt_d = cnt_q;
    run_d = run_q;
    if (load) begin
      sh_d  = data_in;
      crc_d = '1;
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      sh_d  = sh_q >> 1;
      crc_d = crc_step;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST_IDX) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      crc_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (en) begin
      sh_q  <= sh_d;
      crc_q <= crc_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign crc_out   = crc_q;
  assign last_step = run_q && (cnt_q == LAST_IDX);
endmodule

// File: rtl/mhf_bin_table.sv
module mhf_bin_table #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      set_en,
  input  logic [$clog2(WORDS)-1:0]  word_sel,
  input  logic [$clog2(WORD_W)-1:0] bit_sel,
  output logic                      hit
);
  logic [WORD_W-1:0] word_q [WORDS];
  logic [WORD_W-1:0] bit_mask;

  assign bit_mask = WORD_W'(1) << bit_sel;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic              wen;
    logic [WORD_W-1:0] word_d;

    always_comb begin
      wen    = clr | (set_en && (word_sel == w[$clog2(WORDS)-1:0]));
      word_d = clr ? '0 : (word_q[w] | bit_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[w] <= '0;
      else if (wen) word_q[w] <= word_d;
    end
  end

  assign hit = word_q[word_sel][bit_sel];
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic track,
  input  logic rej_level,
  input  logic finish_rx,
  input  logic promisc,
  input  logic hit,
  output logic dec_valid,
  output logic dec_accept
);
  logic rej_q, rej_d, rej_en;
  logic valid_d, accept_d;

  always_comb begin
    rej_en   = start | track;
    rej_d    = start ? 1'b0 : (rej_q | rej_level);
    valid_d  = finish_rx;
    accept_d = finish_rx && !(rej_q || rej_level) && (promisc || hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rej_q <= 1'b0;
    else if (rej_en) rej_q <= rej_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= valid_d;
      dec_accept <= accept_d;
    end
  end
endmodule

// File: rtl/hashed_mac_filter.sv
module hashed_mac_filter
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_W    = MAC_W,
  parameter int unsigned HASH_W    = CRC_W,
  parameter logic [HASH_W-1:0] POLY = CRC_POLY,
  parameter int unsigned TBL_WORDS = 4,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned IG_BIT    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_clear,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              rx_valid,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic              promisc,
  input  logic              reject_in,
  input  logic              reject_invert,
  output logic              busy,
  output logic              dec_valid,
  output logic              dec_accept
);
  localparam int unsigned WSEL_W = $clog2(TBL_WORDS);
  localparam int unsigned BSEL_W = $clog2(WORD_W);
  localparam int unsigned N_TBL  = 2;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  fsm_t state_q, state_d;
  op_t  op_q, op_d;
  logic grp_q, grp_d;
  logic idle, start_rx, start_set, clr_tbl, load, ctl_en;
  logic [ADDR_W-1:0] load_addr;
  logic [HASH_W-1:0] crc;
  logic crc_last;
  logic fin_load, fin_rx;
  logic [WSEL_W-1:0] word_sel;
  logic [BSEL_W-1:0] bit_sel;
  logic [N_TBL-1:0]  hits;
  logic hit_sel;

  always_comb begin
    idle      = (state_q == ST_IDLE);
    start_rx  = idle && rx_valid;
    start_set = idle && !rx_valid && cmd_valid && !cmd_clear;
    clr_tbl   = idle && !rx_valid && cmd_valid && cmd_clear;
    load      = start_rx || start_set;
    load_addr = rx_valid ? rx_addr : cmd_addr;
    fin_load  = (state_q == ST_FINISH) && (op_q == OP_LOAD);
    fin_rx    = (state_q == ST_FINISH) && (op_q == OP_RECV);
    word_sel  = crc[HASH_W-1 -: WSEL_W];
    bit_sel   = crc[HASH_W-1-WSEL_W -: BSEL_W];
    ctl_en    = load;
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    grp_d   = grp_q;
    case (state_q)
      ST_IDLE: if (load) begin
        state_d = ST_HASH;
        op_d    = start_rx ? OP_RECV : OP_LOAD;
        grp_d   = load_addr[IG_BIT];
      end
      ST_HASH:   if (crc_last) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      op_q  <= OP_RECV;
      grp_q <= 1'b0;
    end else if (ctl_en) begin
      op_q  <= op_d;
      grp_q <= grp_d;
    end
  end

  mhf_crc_serial #(.DATA_W(ADDR_W), .CRC_W(HASH_W), .POLY(POLY)) u_crc (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load      (load),
    .data_in   (load_addr),
    .crc_out   (crc),
    .last_step (crc_last)
  );

  // table 0: individual addresses, table 1: group addresses
  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    mhf_bin_table #(.WORDS(TBL_WORDS), .WORD_W(WORD_W)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .clr      (clr_tbl),
      .set_en   (fin_load && (grp_q == t[0])),
      .word_sel (word_sel),
      .bit_sel  (bit_sel),
      .hit      (hits[t])
    );
  end

  assign hit_sel = hits[grp_q];

  mhf_decide u_dec (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .start      (start_rx),
    .track      (!idle),
    .rej_level  (reject_in ^ reject_invert),
    .finish_rx  (fin_rx),
    .promisc    (promisc),
    .hit        (hit_sel),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept)
  );

  assign busy = !idle;
endmodule

// File: rtl/hashed_mac_filter_chk.sv
module hashed_mac_filter_chk #(
  parameter int unsigned BUSY_CYCLES = 49
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_clear,
  input logic rx_valid,
  input logic promisc,
  input logic reject_in,
  input logic reject_invert,
  input logic busy,
  input logic dec_valid,
  input logic dec_accept
);
  logic [7:0] run_cnt;
  logic       rej_seen_q;
  logic       eff_rej;
  logic       rej_any;

  assign eff_rej = reject_in ^ reject_invert;
  assign rej_any = rej_seen_q | (busy & eff_rej);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= (run_cnt == 8'hFF) ? run_cnt : run_cnt + 8'd1;
    else           run_cnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rej_seen_q <= 1'b0;
    else if (!busy)   rej_seen_q <= 1'b0;
    else if (eff_rej) rej_seen_q <= 1'b1;
  end

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == 8'(BUSY_CYCLES)));

  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(busy) && !busy);

  assert_accept_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept);

  assert_start_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rx_valid || (cmd_valid && !cmd_clear)));

  assert_reject_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(rej_any)) |-> !dec_accept);

  assert_promisc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(promisc) && !$past(rej_any)) |-> dec_accept);
endmodule

bind hashed_mac_filter hashed_mac_filter_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_clear     (cmd_clear),
  .rx_valid      (rx_valid),
  .promisc       (promisc),
  .reject_in     (reject_in),
  .reject_invert (reject_invert),
  .busy          (busy),
  .dec_valid     (dec_valid),
  .dec_accept    (dec_accept)
);

// File: tb/hashed_mac_filter_test.sv
module hashed_mac_filter_test;
  logic        clk;
  logic        rst_n;
  logic        cmd_valid, cmd_clear, rx_valid;
  logic [47:0] cmd_addr, rx_addr;
  logic        promisc, reject_in, reject_invert;
  logic        busy, dec_valid, dec_accept;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;
  logic [63:0] mdl [2];   // model tables: [0] individual, [1] group

  hashed_mac_filter uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_clear(cmd_clear),
    .cmd_addr(cmd_addr), .rx_valid(rx_valid), .rx_addr(rx_addr),
    .promisc(promisc), .reject_in(reject_in), .reject_invert(reject_invert),
    .busy(busy), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // vector layout: {req[3:0], kind[1:0] (0 rx,1 set,2 clear), addr[47:0], promisc, rej_at[6:0] (127 none), invert}
  localparam logic [47:0] A_IND = 48'h0A1B_2C3D_4E02;
  localparam logic [47:0] G_GRP = 48'h00CC_0001_5E01;
  localparam logic [47:0] B_IND = 48'h7766_5544_3320;
  localparam int NV = 13;
  localparam logic [62:0] VEC [NV] = '{
    {4'd4, 2'd0, A_IND, 1'b0, 7'd127, 1'b0},  // R4 empty tables reject
    {4'd3, 2'd1, A_IND, 1'b0, 7'd127, 1'b0},  // R3 load individual
    {4'd3, 2'd0, A_IND, 1'b0, 7'd127, 1'b0},  // R3 accept loaded
    {4'd3, 2'd1, G_GRP, 1'b0, 7'd127, 1'b0},  // R3 load group
    {4'd3, 2'd0, G_GRP, 1'b0, 7'd127, 1'b0},  // R3 accept group
    {4'd7, 2'd0, B_IND, 1'b1, 7'd127, 1'b0},  // R7 promiscuous accept
    {4'd8, 2'd0, B_IND, 1'b1, 7'd10,  1'b0},  // R8 reject mid-window
    {4'd8, 2'd0, A_IND, 1'b0, 7'd127, 1'b1},  // R8 inverted, held high: keep
    {4'd8, 2'd0, A_IND, 1'b0, 7'd48,  1'b1},  // R8 inverted, low in last cycle
    {4'd8, 2'd0, G_GRP, 1'b1, 7'd0,   1'b0},  // R8 reject in first busy cycle
    {4'd5, 2'd2, A_IND, 1'b0, 7'd127, 1'b0},  // R5 clear
    {4'd5, 2'd0, A_IND, 1'b0, 7'd127, 1'b0},  // R5 individual gone
    {4'd5, 2'd0, G_GRP, 1'b0, 7'd127, 1'b0}   // R5 group gone
  };

  function automatic logic [5:0] ref_bin(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[31] ^ a[i];
      c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
    end
    return c[31:26];
  endfunction

  // same=1: same bin as want; same=0: bin unset in the model table
  function automatic logic [47:0] find_addr(input logic [47:0] base, input logic [5:0] want,
                                            input bit same, input logic [47:0] avoid);
    for (int i = 1; i < 4096; i++) begin
      logic [47:0] a = base;
      a[47:24] = base[47:24] + 24'(i);
      if (a != avoid) begin
        if (same && ref_bin(a) == want) return a;
        if (!same && !mdl[a[0]][ref_bin(a)]) return a;
      end
    end
    return base;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_rx(input logic [47:0] a, input bit prom, input int rej_at, input bit inv,
                       input int inj_j, input logic [47:0] side, input bit side_start, input string tag);
    bit exp, got, tm_ok;
    exp = (rej_at < 0) && (prom || mdl[a[0]][ref_bin(a)]);
    tm_ok = 1;
    @(negedge clk);
    rx_valid = 1; rx_addr = a; promisc = prom; reject_invert = inv; reject_in = inv;
    if (side_start) begin cmd_valid = 1; cmd_clear = 0; cmd_addr = side; end
    for (int j = 0; j < 49; j++) begin
      @(negedge clk);
      if (!busy || dec_valid) tm_ok = 0;
      reject_in = inv ^ (j == rej_at);
      if (j == inj_j) begin
        rx_valid = 1; rx_addr = side; cmd_valid = 1; cmd_clear = 0; cmd_addr = side;
      end else begin
        rx_valid = 0; cmd_valid = 0;
      end
    end
    @(negedge clk);
    reject_in = inv; rx_valid = 0; cmd_valid = 0;
    if (busy || !dec_valid) tm_ok = 0;
    got = dec_accept;
    @(negedge clk);
    if (dec_valid || dec_accept) tm_ok = 0;
    check(tm_ok, "R6 receive busy/pulse timing", 64'(tm_ok), 64'd1);
    check(got == exp, tag, 64'(got), 64'(exp));
  endtask

  task automatic do_set(input logic [47:0] a, input string tag);
    bit tm_ok = 1;
    @(negedge clk);
    cmd_valid = 1; cmd_clear = 0; cmd_addr = a;
    for (int j = 0; j < 49; j++) begin
      @(negedge clk);
      cmd_valid = 0;
      if (!busy || dec_valid) tm_ok = 0;
    end
    @(negedge clk);
    if (busy || dec_valid) tm_ok = 0;
    mdl[a[0]][ref_bin(a)] = 1'b1;
    check(tm_ok, tag, 64'(tm_ok), 64'd1);
  endtask

  task automatic do_clear();
    @(negedge clk);
    cmd_valid = 1; cmd_clear = 1;
    @(negedge clk);
    cmd_valid = 0; cmd_clear = 0;
    check(!busy && !dec_valid, "R5 clear raises no busy", 64'(busy), 64'd0);
    mdl[0] = '0; mdl[1] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] a2, a3, gx, xa, ya, za;
    rst_n = 0; cmd_valid = 0; cmd_clear = 0; cmd_addr = '0; rx_valid = 0; rx_addr = '0;
    promisc = 0; reject_in = 0; reject_invert = 0;
    mdl[0] = '0; mdl[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !dec_valid && !dec_accept, "R1 reset outputs", {61'd0, busy, dec_valid, dec_accept}, 64'd0);

    for (int v = 0; v < NV; v++) begin
      logic [62:0] e = VEC[v];
      int ra = (e[7:1] == 7'd127) ? -1 : int'(e[7:1]);
      case (e[58:57])
        2'd0: do_rx(e[56:9], e[8], ra, e[0], -1, '0, 0, $sformatf("R%0d vector %0d", e[62:59], v));
        2'd1: do_set(e[56:9], $sformatf("R%0d vector %0d load timing", e[62:59], v));
        default: do_clear();
      endcase
    end

    // R10 aliasing and R2 bin mapping
    do_set(A_IND, "R3 reload individual");
    a2 = find_addr(A_IND, ref_bin(A_IND), 1, A_IND);
    do_rx(a2, 0, -1, 0, -1, '0, 0, "R10 alias of loaded bin accepted");
    a3 = find_addr(A_IND, 6'd0, 0, A_IND);
    do_rx(a3, 0, -1, 0, -1, '0, 0, "R2 different bin rejected");
    gx = find_addr(G_GRP, ref_bin(A_IND), 1, G_GRP);
    do_rx(gx, 0, -1, 0, -1, '0, 0, "R4 same bin in other table rejected");

    // R9 request while busy is ignored
    xa = find_addr(B_IND, 6'd0, 0, A_IND);
    ya = find_addr(xa, 6'd0, 0, xa);
    do_rx(xa, 0, -1, 0, 5, ya, 0, "R9 receive with injected request");
    do_rx(ya, 0, -1, 0, -1, '0, 0, "R9 load during busy was ignored");
    // R9 receive wins over simultaneous command
    za = find_addr(ya, 6'd0, 0, ya);
    do_rx(A_IND, 0, -1, 0, -1, za, 1, "R9 receive taken over command");
    do_rx(za, 0, -1, 0, -1, '0, 0, "R9 simultaneous load dropped");

    // R1 reset in the middle of a load
    @(negedge clk);
    cmd_valid = 1; cmd_clear = 0; cmd_addr = G_GRP;
    @(negedge clk);
    cmd_valid = 0;
    repeat (10) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(!busy && !dec_valid, "R1 busy cleared by reset", 64'(busy), 64'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    mdl[0] = '0; mdl[1] = '0;
    do_rx(A_IND, 0, -1, 0, -1, '0, 0, "R1 tables empty after reset");
    do_rx(G_GRP, 0, -1, 0, -1, '0, 0, "R1 interrupted load not stored");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule